// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register state machine of a byte-wide parallel flash device with a 17-bit address. It watches the write-enable strobe. On every high-to-low transition it samples the address and data buses and steps through the unlock-and-command sequences the device accepts. Completed sequences become single-clock action pulses for the program and erase engines, which sit outside this block together with the memory array.

A program action carries the 17-bit target address and the data byte. A sector-erase action carries a 3-bit sector number. A chip-erase action carries nothing. The block also holds a read-mode select: it either lets the array answer reads, or it switches reads to an identifier byte that the block derives from the low address bit. Reads never change the decoder state, so the bus may read at any point of a sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read-mode select is 0, meaning array reads, and no action pulse is active, so reads need no prior command.
- R2: A write is taken only on the clock that first sees `wr_n` low after it was high. Holding `wr_n` low for further clocks adds no write, and the decoder state changes only in the clock after a taken write.
- R3: Every command needs an unlock pair first: data AAh with address low bits 14:0 equal to 5555h, then data 55h with low bits equal to 2AAAh. Address bits 16 and 15 are ignored in every unlock and command-code cycle.
- R4: Unlock pair, then F0h at 5555h, sets the read-mode select to 0.
- R5: Unlock pair, then 90h at 5555h, sets the read-mode select to 1. While it is 1, `id_byte` is 01h when address bit 0 is 0 and 20h when it is 1.
- R6: Unlock pair, then A0h at 5555h, arms program. The next write raises `pgm_go` for one clock with its full 17-bit address on `pgm_addr` and its data on `pgm_data`, and the read-mode select returns to 0.
- R7: Unlock pair, 80h at 5555h, a second unlock pair, then 10h at 5555h raises `chip_go` for one clock and clears the read-mode select.
- R8: The same five-write prefix followed by 30h at any address raises `sect_go` for one clock. `sect_num` carries address bits 16:14 of that write, and the read-mode select clears.
- R9: A write that does not fit the current step returns the decoder to waiting for the first unlock write and leaves the read-mode select unchanged.
- R10: Data F0h at any address, in any step except the program-data write, returns the decoder to waiting and sets the read-mode select to 0. F0h given as program data is programmed.
- R11: At most one of `pgm_go`, `chip_go` and `sect_go` is high in a clock, and none stays high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Write enable, active low, synchronous to clk |
| addr | input | 17 | Address bus |
| wdata | input | 8 | Data bus |
| pgm_go | output | 1 | One-clock program request |
| pgm_addr | output | 17 | Address of the program request |
| pgm_data | output | 8 | Data of the program request |
| chip_go | output | 1 | One-clock chip-erase request |
| sect_go | output | 1 | One-clock sector-erase request |
| sect_num | output | 3 | Sector of the erase request |
| id_sel | output | 1 | Read-mode select: 0 array, 1 identifier |
| id_byte | output | 8 | Identifier byte for the present address |

## Verification
The sequences are driven with address bits 16 and 15 set and cleared. This separates decoding on the low address bits from decoding on the full address. Full program, chip-erase and sector-erase runs go through all eight sectors, and program data of F0h shows that the program-data step is exempt from the reset code. Sequences broken by a wrong address, wrong data, or F0h at an inner step show the difference between an abort that keeps the identifier mode and a reset that leaves it. Writes held low for several clocks show whether a level is mistaken for an edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PGM,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } cmd_state_e;

    localparam int NUM_HITS = 6;
    localparam int HX_KEY1  = 0;
    localparam int HX_AUTO  = 1;
    localparam int HX_PROG  = 2;
    localparam int HX_ERASE = 3;
    localparam int HX_CHIP  = 4;
    localparam int HX_KEY2  = 5;

    localparam logic [7:0] CODE_KEY1  = 8'hAA;
    localparam logic [7:0] CODE_KEY2  = 8'h55;
    localparam logic [7:0] CODE_RESET = 8'hF0;
    localparam logic [7:0] CODE_AUTO  = 8'h90;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;

    function automatic logic [7:0] hit_code(input int idx);
        case (idx)
            HX_KEY1:  return CODE_KEY1;
            HX_AUTO:  return CODE_AUTO;
            HX_PROG:  return CODE_PROG;
            HX_ERASE: return CODE_ERASE;
            HX_CHIP:  return CODE_CHIP;
            default:  return CODE_KEY2;
        endcase
    endfunction

endpackage

// File: rtl/flash_we_edge.sv
module flash_we_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic strobe
);
    logic wr_d, wr_q;

    always_comb begin
        wr_d = wr_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_d;
    end

    assign strobe = wr_q & ~wr_n;
endmodule

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int MATCH_W = 15,
    parameter int DATA_W  = 8,
    parameter logic [MATCH_W-1:0] CMD_ADDR = 'h5555,
    parameter logic [MATCH_W-1:0] ALT_ADDR = 'h2AAA
) (
    input  logic [MATCH_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_HITS-1:0] hits,
    output logic                is_reset,
    output logic                is_sect
);
    logic at_cmd, at_alt;

    assign at_cmd   = (addr_lo == CMD_ADDR);
    assign at_alt   = (addr_lo == ALT_ADDR);
    assign is_reset = (wdata == DATA_W'(CODE_RESET));
    assign is_sect  = (wdata == DATA_W'(CODE_SECT));

    for (genvar i = 0; i < NUM_HITS; i++) begin : g_hit
        if (i == HX_KEY2) begin : g_alt
            assign hits[i] = at_alt && (wdata == DATA_W'(hit_code(i)));
        end else begin : g_cmd
            assign hits[i] = at_cmd && (wdata == DATA_W'(hit_code(i)));
        end
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3,
    parameter logic [DATA_W-1:0] ID_LO = 'h01,
    parameter logic [DATA_W-1:0] ID_HI = 'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_HITS-1:0] hits,
    input  logic                is_reset,
    input  logic                is_sect,
    output logic                pgm_go,
    output logic [ADDR_W-1:0]   pgm_addr,
    output logic [DATA_W-1:0]   pgm_data,
    output logic                chip_go,
    output logic                sect_go,
    output logic [SECT_W-1:0]   sect_num,
    output logic                id_sel,
    output logic [DATA_W-1:0]   id_byte
);
    typedef struct packed {
        cmd_state_e        st;
        logic              id;
        logic              pgm;
        logic              chip;
        logic              sect;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic [SECT_W-1:0] snum;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.pgm  = 1'b0;
        r_d.chip = 1'b0;
        r_d.sect = 1'b0;
        if (strobe) begin
            r_d.st = ST_IDLE;
            if (is_reset && r_q.st != ST_PGM) begin
                r_d.id = 1'b0;
            end else begin
                case (r_q.st)
                    ST_IDLE: if (hits[HX_KEY1]) r_d.st = ST_KEY1;
                    ST_KEY1: if (hits[HX_KEY2]) r_d.st = ST_KEY2;
                    ST_KEY2: begin
                        if (hits[HX_AUTO])       r_d.id = 1'b1;
                        else if (hits[HX_PROG])  r_d.st = ST_PGM;
                        else if (hits[HX_ERASE]) r_d.st = ST_ERA1;
                    end
                    ST_PGM: begin
                        r_d.pgm   = 1'b1;
                        r_d.paddr = addr;
                        r_d.pdata = wdata;
                        r_d.id    = 1'b0;
                    end
                    ST_ERA1: if (hits[HX_KEY1]) r_d.st = ST_ERA2;
                    ST_ERA2: if (hits[HX_KEY2]) r_d.st = ST_ERA3;
                    ST_ERA3: begin
                        if (hits[HX_CHIP]) begin
                            r_d.chip = 1'b1;
                            r_d.id   = 1'b0;
                        end else if (is_sect) begin
                            r_d.sect = 1'b1;
                            r_d.snum = addr[ADDR_W-1 -: SECT_W];
                            r_d.id   = 1'b0;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pgm_go   = r_q.pgm;
    assign pgm_addr = r_q.paddr;
    assign pgm_data = r_q.pdata;
    assign chip_go  = r_q.chip;
    assign sect_go  = r_q.sect;
    assign sect_num = r_q.snum;
    assign id_sel   = r_q.id;
    assign id_byte  = addr[0] ? ID_HI : ID_LO;

    assert_actions_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_go, chip_go, sect_go}));

    assert_pgm_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_go |=> !pgm_go);

    assert_chip_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chip_go |=> !chip_go);

    assert_sect_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sect_go |=> !sect_go);

    assert_action_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_go || chip_go || sect_go) |-> $past(strobe));

    assert_mode_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe) |-> $stable(id_sel));

    assert_action_clears_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_go || chip_go || sect_go) |-> !id_sel);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              pgm_go,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              chip_go,
    output logic              sect_go,
    output logic [SECT_W-1:0] sect_num,
    output logic              id_sel,
    output logic [DATA_W-1:0] id_byte
);
    localparam int MATCH_W = ADDR_W - 2;

    logic                strobe;
    logic [NUM_HITS-1:0] hits;
    logic                is_reset;
    logic                is_sect;

    flash_we_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .strobe (strobe)
    );

    flash_cmd_match #(
        .MATCH_W (MATCH_W),
        .DATA_W  (DATA_W)
    ) u_match (
        .addr_lo  (addr[MATCH_W-1:0]),
        .wdata    (wdata),
        .hits     (hits),
        .is_reset (is_reset),
        .is_sect  (is_sect)
    );

    flash_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SECT_W (SECT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .addr     (addr),
        .wdata    (wdata),
        .hits     (hits),
        .is_reset (is_reset),
        .is_sect  (is_sect),
        .pgm_go   (pgm_go),
        .pgm_addr (pgm_addr),
        .pgm_data (pgm_data),
        .chip_go  (chip_go),
        .sect_go  (sect_go),
        .sect_num (sect_num),
        .id_sel   (id_sel),
        .id_byte  (id_byte)
    );
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        pgm_go, chip_go, sect_go, id_sel;
    logic [16:0] pgm_addr;
    logic [7:0]  pgm_data, id_byte;
    logic [2:0]  sect_num;

    int checks = 0;
    int errors = 0;
    int n_pgm = 0, n_chip = 0, n_sect = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
        .pgm_go(pgm_go), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .chip_go(chip_go), .sect_go(sect_go), .sect_num(sect_num),
        .id_sel(id_sel), .id_byte(id_byte)
    );

    // behavioural reference: queue of accepted writes of the running sequence
    typedef struct { logic [16:0] a; logic [7:0] d; } wr_t;
    wr_t seq[$];
    bit  m_prev_we = 1;
    bit  m_id = 0;
    bit  e_pgm = 0, e_chip = 0, e_sect = 0;
    logic [16:0] e_paddr;
    logic [7:0]  e_pdata;
    logic [2:0]  e_snum;

    function automatic bit low_is(input logic [16:0] a, input logic [14:0] v);
        return a[14:0] == v;
    endfunction

    always @(posedge clk) begin
        e_pgm = 0; e_chip = 0; e_sect = 0;
        if (!rst_n) begin
            m_prev_we = 1; m_id = 0; seq.delete();
        end else begin
            bit stb;
            stb = m_prev_we && !wr_n;
            m_prev_we = wr_n;
            if (stb) begin
                bit arm;
                wr_t w;
                w.a = addr; w.d = wdata;
                arm = (seq.size() == 3) && (seq[2].d == 8'hA0);
                if (w.d == 8'hF0 && !arm) begin
                    seq.delete(); m_id = 0;
                end else begin
                    case (seq.size())
                        0: if (w.d == 8'hAA && low_is(w.a, 15'h5555)) seq.push_back(w);
                        1: if (w.d == 8'h55 && low_is(w.a, 15'h2AAA)) seq.push_back(w); else seq.delete();
                        2: begin
                            if (low_is(w.a, 15'h5555) && (w.d == 8'hA0 || w.d == 8'h80)) seq.push_back(w);
                            else begin
                                if (low_is(w.a, 15'h5555) && w.d == 8'h90) m_id = 1;
                                seq.delete();
                            end
                        end
                        3: begin
                            if (arm) begin
                                e_pgm = 1; e_paddr = w.a; e_pdata = w.d; m_id = 0; seq.delete();
                            end else if (w.d == 8'hAA && low_is(w.a, 15'h5555)) seq.push_back(w);
                            else seq.delete();
                        end
                        4: if (w.d == 8'h55 && low_is(w.a, 15'h2AAA)) seq.push_back(w); else seq.delete();
                        default: begin
                            if (w.d == 8'h10 && low_is(w.a, 15'h5555)) begin
                                e_chip = 1; m_id = 0;
                            end else if (w.d == 8'h30) begin
                                e_sect = 1; e_snum = w.a[16:14]; m_id = 0;
                            end
                            seq.delete();
                        end
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // every-clock comparison, half a period after the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 pgm_go", 32'(pgm_go), 32'(e_pgm));
            chk("R7 chip_go", 32'(chip_go), 32'(e_chip));
            chk("R8 sect_go", 32'(sect_go), 32'(e_sect));
            chk("R9 id_sel", 32'(id_sel), 32'(m_id));
            if (e_pgm) begin
                chk("R6 pgm_addr", 32'(pgm_addr), 32'(e_paddr));
                chk("R6 pgm_data", 32'(pgm_data), 32'(e_pdata));
            end
            if (e_sect) chk("R8 sect_num", 32'(sect_num), 32'(e_snum));
            if (m_id) chk("R5 id_byte", 32'(id_byte), addr[0] ? 32'h20 : 32'h01);
            chk("R11 one action", 32'(int'(pgm_go) + int'(chip_go) + int'(sect_go) <= 1), 32'd1);
            if (pgm_go) n_pgm++;
            if (chip_go) n_chip++;
            if (sect_go) n_sect++;
        end
    end

    task automatic wr(input logic [16:0] a, input logic [7:0] d, input int hold = 1);
        @(posedge clk); #1;
        wr_n = 1'b0; addr = a; wdata = d;
        repeat (hold) @(posedge clk);
        #1 wr_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic unlock(input logic [16:0] hi);
        wr(hi | 17'h05555, 8'hAA);
        wr(hi | 17'h02AAA, 8'h55);
    endtask

    task automatic settle;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 id_sel", 32'(id_sel), 32'd0);
        chk("R1 pulses", 32'({pgm_go, chip_go, sect_go}), 32'd0);
        rst_n = 1'b1;
        settle();
        chk("R1 id_sel after release", 32'(id_sel), 32'd0);

        // R3 R5: unlock with A15/A16 set, autoselect at 5555h with A16 set
        wr(17'h0D555, 8'hAA);
        wr(17'h12AAA, 8'h55);
        wr(17'h15555, 8'h90);
        settle();
        chk("R3 R5 autoselect", 32'(id_sel), 32'd1);
        addr = 17'h00000; #1;
        chk("R5 id low", 32'(id_byte), 32'h01);
        addr = 17'h00001; #1;
        chk("R5 id high", 32'(id_byte), 32'h20);

        // R9: broken sequence keeps identifier mode
        wr(17'h05555, 8'hAA);
        wr(17'h02AAB, 8'h55);
        wr(17'h05555, 8'h90);
        settle();
        chk("R9 abort keeps mode", 32'(id_sel), 32'd1);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h56);
        settle();
        chk("R9 wrong data keeps mode", 32'(id_sel), 32'd1);

        // R4: read/reset command
        unlock(17'h18000);
        wr(17'h05555, 8'hF0);
        settle();
        chk("R4 read reset", 32'(id_sel), 32'd0);

        // R3: wrong unlock address then autoselect code has no effect
        wr(17'h05555, 8'hAA);
        wr(17'h05555, 8'h55);
        wr(17'h05555, 8'h90);
        settle();
        chk("R3 bad unlock", 32'(id_sel), 32'd0);

        // R10: bare F0 in idle and F0 inside erase prefix
        unlock(17'h0);
        wr(17'h05555, 8'h90);
        wr(17'h00123, 8'hF0);
        settle();
        chk("R10 bare reset", 32'(id_sel), 32'd0);
        unlock(17'h0);
        wr(17'h05555, 8'h90);
        unlock(17'h0);
        wr(17'h05555, 8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h00777, 8'hF0);
        wr(17'h05555, 8'h10);
        settle();
        chk("R10 reset mid erase", 32'(id_sel), 32'd0);
        chk("R10 no chip erase", 32'(n_chip), 32'd0);

        // R6: program from identifier mode, A16 carried into address
        unlock(17'h0);
        wr(17'h05555, 8'h90);
        unlock(17'h08000);
        wr(17'h0D555, 8'hA0);
        wr(17'h1ABCD, 8'h5A);
        settle();
        chk("R6 count", 32'(n_pgm), 32'd1);
        chk("R6 addr held", 32'(pgm_addr), 32'h1ABCD);
        chk("R6 data held", 32'(pgm_data), 32'h5A);
        chk("R6 back to array", 32'(id_sel), 32'd0);

        // R10: F0 as program data is programmed
        unlock(17'h0);
        wr(17'h05555, 8'hA0);
        wr(17'h00042, 8'hF0);
        settle();
        chk("R10 program F0", 32'(n_pgm), 32'd2);
        chk("R10 program F0 data", 32'(pgm_data), 32'hF0);

        // R2: long write-enable low counts once
        unlock(17'h0);
        wr(17'h05555, 8'hA0, 5);
        wr(17'h03000, 8'h11, 6);
        settle();
        chk("R2 held low single", 32'(n_pgm), 32'd3);

        // R7: chip erase
        unlock(17'h0);
        wr(17'h05555, 8'h80);
        unlock(17'h18000);
        wr(17'h05555, 8'h10);
        settle();
        chk("R7 chip count", 32'(n_chip), 32'd1);

        // R8: sector erase of every sector
        for (int s = 0; s < 8; s++) begin
            unlock(17'h0);
            wr(17'h05555, 8'h80);
            unlock(17'h0);
            wr({3'(s), 14'h0155}, 8'h30);
            settle();
            chk("R8 sector number", 32'(sect_num), 32'(s));
        end
        chk("R8 sector count", 32'(n_sect), 32'd8);
        chk("R11 totals", 32'(n_pgm + n_chip + n_sect), 32'd12);

        settle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule